// File: doc/BRIEF.md
# Multithreaded Register Rename Unit

This block renames a group of up to three instructions per cycle for one hardware thread, chosen per cycle from two or more threads. Each thread owns a private table that maps its logical registers to physical registers, while every thread draws new physical registers from one shared pool. The pool is managed as a single in-order free list. For each slot the block returns the physical tags of both sources, the freshly allocated destination tag, and the mapping that the destination held before. The caller keeps that previous mapping and hands it back through the release port once the instruction retires.

Sources inside a group see the renames made by earlier slots of the same group, so dependent instructions can be renamed together. A group is taken whole or not at all. A per-thread restore input puts one thread's table back to its reset contents. All rename results are combinational in the cycle the group is presented, and the table and free-list updates land on the next rising clock edge.

Top module: `mt_rename`

## Requirements
- R1: After reset, logical register r of thread t maps to physical register t*LREGS+r. A source with no producer earlier in its group returns its thread's table entry, and logical register 0 always returns t*LREGS.
- R2: Threads are isolated. The same logical number resolves to different physical registers in different threads, and renaming in one thread leaves the other threads' mappings unchanged.
- R3: After reset the free list holds THREADS*LREGS up to PREGS-1 in ascending order. Allocating slots take entries from its head in slot order, with slot 0 first.
- R4: For each allocating slot, ren_pold_o gives the mapping the destination held before the group. From the next cycle the thread's table holds the new tag.
- R5: A source that names the destination of an earlier allocating slot in the same group gets that slot's new tag. When several earlier slots write it, the latest one wins.
- R6: When two slots of a group write the same destination, the later slot's old mapping is the earlier slot's new tag, and the table ends up holding the later tag.
- R7: A slot allocates nothing and consumes no free entry if it is invalid, if its destination-valid bit is 0, or if its destination is logical register 0.
- R8: If the free list holds fewer entries than the group's allocation count, ren_accept_o is 0, ren_alloc_o is 0, and neither the tables nor the free list change.
- R9: A tag presented on the release port is appended to the free-list tail. It can be allocated from the following cycle, after every entry already queued.
- R10: A restore resets one thread's table at the next edge. A group of that same thread is rejected in the restore cycle, other threads rename normally, and the free list is untouched.
- R11: With no valid slot, ren_accept_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ren_tid_i | input | TID_W | Thread that owns the group |
| ren_valid_i | input | SLOTS | Slot holds an instruction |
| ren_dst_valid_i | input | SLOTS | Slot writes a destination |
| ren_dst_i | input | SLOTS*LOG_W | Logical destination per slot |
| ren_srca_i | input | SLOTS*LOG_W | First logical source per slot |
| ren_srcb_i | input | SLOTS*LOG_W | Second logical source per slot |
| ren_accept_o | output | 1 | Group renamed this cycle |
| ren_alloc_o | output | SLOTS | Slot received a new physical register |
| ren_pdst_o | output | SLOTS*PHYS_W | New physical destination (0 when not allocated) |
| ren_pold_o | output | SLOTS*PHYS_W | Previous mapping of the destination |
| ren_psrca_o | output | SLOTS*PHYS_W | Physical first source |
| ren_psrcb_o | output | SLOTS*PHYS_W | Physical second source |
| rel_valid_i | input | 1 | Return a physical register to the free list |
| rel_tag_i | input | PHYS_W | Register being returned |
| restore_valid_i | input | 1 | Reset one thread's map |
| restore_tid_i | input | TID_W | Thread whose map is reset |

## Verification
The bench uses the default build: two threads of 32 logical registers, 96 physical registers and three slots. That leaves a shared pool of exactly 32 free entries. The pool is small enough that about ten full groups drain it, which brings the exact-fit boundary, the one-short stall and the empty-list case within a few dozen cycles. Three slots are the fewest that allow a source to choose between two earlier writers of the same register, and that also allow a destination to be written twice with a bypassed source in between.

// File: rtl/rn_pkg.sv
package rn_pkg;

  localparam int unsigned RN_THREADS_DEF = 2;
  localparam int unsigned RN_LREGS_DEF   = 32;
  localparam int unsigned RN_PREGS_DEF   = 96;
  localparam int unsigned RN_SLOTS_DEF   = 3;

  // home physical register of logical register lr in thread t
  function automatic int unsigned rn_home(int unsigned t, int unsigned lr, int unsigned lregs);
    return t * lregs + lr;
  endfunction

endpackage

// File: rtl/rn_map_table.sv
module rn_map_table import rn_pkg::*; #(
  parameter int unsigned THREADS = RN_THREADS_DEF,
  parameter int unsigned LREGS   = RN_LREGS_DEF,
  parameter int unsigned SLOTS   = RN_SLOTS_DEF,
  parameter int unsigned TID_W   = 1,
  parameter int unsigned LOG_W   = 5,
  parameter int unsigned PHYS_W  = 7
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [TID_W-1:0]              tid,
  input  logic [SLOTS-1:0][LOG_W-1:0]   rd_a,
  input  logic [SLOTS-1:0][LOG_W-1:0]   rd_b,
  input  logic [SLOTS-1:0][LOG_W-1:0]   rd_d,
  output logic [SLOTS-1:0][PHYS_W-1:0]  tbl_a,
  output logic [SLOTS-1:0][PHYS_W-1:0]  tbl_b,
  output logic [SLOTS-1:0][PHYS_W-1:0]  tbl_d,
  input  logic [SLOTS-1:0]              wr_en,
  input  logic [SLOTS-1:0][PHYS_W-1:0]  wr_tag,
  input  logic                          restore_en,
  input  logic [TID_W-1:0]              restore_tid
);

  logic [PHYS_W-1:0] map_q [THREADS][LREGS];
  logic [PHYS_W-1:0] map_d [THREADS][LREGS];
  logic              map_we;

  assign map_we = restore_en | (|wr_en);

  // read ports, one set per slot
  for (genvar s = 0; s < SLOTS; s++) begin : g_rd
    assign tbl_a[s] = map_q[tid][rd_a[s]];
    assign tbl_b[s] = map_q[tid][rd_b[s]];
    assign tbl_d[s] = map_q[tid][rd_d[s]];
  end

  // next state: restore first, then writes in slot order (later slot wins)
  always_comb begin
    map_d = map_q;
    if (restore_en) begin
      for (int r = 0; r < LREGS; r++) begin
        map_d[restore_tid][r] = PHYS_W'(rn_home(int'(restore_tid), r, LREGS));
      end
    end
    for (int s = 0; s < SLOTS; s++) begin
      if (wr_en[s]) map_d[tid][rd_d[s]] = wr_tag[s];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int t = 0; t < THREADS; t++) begin
        for (int r = 0; r < LREGS; r++) begin
          map_q[t][r] <= PHYS_W'(rn_home(t, r, LREGS));
        end
      end
    end else if (map_we) begin
      map_q <= map_d;
    end
  end

endmodule

// File: rtl/rn_free_list.sv
module rn_free_list #(
  parameter int unsigned SLOTS  = 3,
  parameter int unsigned FIRST  = 64,
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned PHYS_W = 7,
  parameter int unsigned CNT_W  = 6,
  parameter int unsigned SCW    = 2,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [SCW-1:0]                pop_cnt,
  input  logic                          push_en,
  input  logic [PHYS_W-1:0]             push_tag,
  output logic [SLOTS-1:0][PHYS_W-1:0]  peek,
  output logic [CNT_W-1:0]              count
);

  logic [PHYS_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  head_q, head_d;
  logic [PTR_W-1:0]  tail_q, tail_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              push_ok;
  logic              ptr_we;

  function automatic logic [PTR_W-1:0] adv(logic [PTR_W-1:0] p, int unsigned k);
    int unsigned sum;
    sum = int'(p) + k;
    if (sum >= DEPTH) sum = sum - DEPTH;
    return PTR_W'(sum);
  endfunction

  for (genvar s = 0; s < SLOTS; s++) begin : g_peek
    assign peek[s] = mem_q[adv(head_q, s)];
  end

  assign count = cnt_q;

  always_comb begin
    push_ok = push_en && ((int'(cnt_q) - int'(pop_cnt)) < int'(DEPTH));
    head_d  = adv(head_q, int'(pop_cnt));
    tail_d  = push_ok ? adv(tail_q, 1) : tail_q;
    cnt_d   = CNT_W'(int'(cnt_q) - int'(pop_cnt) + int'(push_ok));
    ptr_we  = push_ok || (pop_cnt != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= CNT_W'(DEPTH);
    end else if (ptr_we) begin
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= PHYS_W'(FIRST + i);
    end else if (push_ok) begin
      mem_q[tail_q] <= push_tag;
    end
  end

endmodule

// File: rtl/rn_group.sv
module rn_group #(
  parameter int unsigned SLOTS  = 3,
  parameter int unsigned LOG_W  = 5,
  parameter int unsigned PHYS_W = 7,
  parameter int unsigned CNT_W  = 6,
  parameter int unsigned SCW    = 2
) (
  input  logic [SLOTS-1:0]              valid,
  input  logic [SLOTS-1:0]              dst_valid,
  input  logic [SLOTS-1:0][LOG_W-1:0]   dst,
  input  logic [SLOTS-1:0][LOG_W-1:0]   srca,
  input  logic [SLOTS-1:0][LOG_W-1:0]   srcb,
  input  logic [SLOTS-1:0][PHYS_W-1:0]  tbl_a,
  input  logic [SLOTS-1:0][PHYS_W-1:0]  tbl_b,
  input  logic [SLOTS-1:0][PHYS_W-1:0]  tbl_d,
  input  logic [SLOTS-1:0][PHYS_W-1:0]  peek,
  input  logic [CNT_W-1:0]              free_cnt,
  input  logic                          blocked,
  output logic                          accept,
  output logic [SLOTS-1:0]              alloc,
  output logic [SCW-1:0]                pop_cnt,
  output logic [SLOTS-1:0][PHYS_W-1:0]  pdst,
  output logic [SLOTS-1:0][PHYS_W-1:0]  pold,
  output logic [SLOTS-1:0][PHYS_W-1:0]  psa,
  output logic [SLOTS-1:0][PHYS_W-1:0]  psb
);

  logic [SLOTS-1:0]             want;
  logic [SLOTS-1:0][PHYS_W-1:0] fresh;
  logic [SCW-1:0]               need;

  // allocation rank: each wanting slot takes the next free-list entry
  always_comb begin
    need = '0;
    for (int s = 0; s < SLOTS; s++) begin
      want[s]  = valid[s] && dst_valid[s] && (dst[s] != '0);
      fresh[s] = peek[need];
      if (want[s]) need = need + SCW'(1);
    end
  end

  always_comb begin
    accept  = (|valid) && !blocked && (int'(free_cnt) >= int'(need));
    alloc   = want & {SLOTS{accept}};
    pop_cnt = accept ? need : '0;
  end

  // in-group forwarding: the latest earlier writer overrides the table
  always_comb begin
    for (int j = 0; j < SLOTS; j++) begin
      psa[j]  = tbl_a[j];
      psb[j]  = tbl_b[j];
      pold[j] = tbl_d[j];
      for (int i = 0; i < j; i++) begin
        if (want[i] && (dst[i] == srca[j])) psa[j]  = fresh[i];
        if (want[i] && (dst[i] == srcb[j])) psb[j]  = fresh[i];
        if (want[i] && (dst[i] == dst[j]))  pold[j] = fresh[i];
      end
      pdst[j] = alloc[j] ? fresh[j] : '0;
    end
  end

endmodule

// File: rtl/mt_rename.sv
module mt_rename import rn_pkg::*; #(
  parameter int unsigned THREADS = RN_THREADS_DEF,
  parameter int unsigned LREGS   = RN_LREGS_DEF,
  parameter int unsigned PREGS   = RN_PREGS_DEF,
  parameter int unsigned SLOTS   = RN_SLOTS_DEF,
  localparam int unsigned TID_W      = (THREADS > 1) ? $clog2(THREADS) : 1,
  localparam int unsigned LOG_W      = $clog2(LREGS),
  localparam int unsigned PHYS_W     = $clog2(PREGS),
  localparam int unsigned MAPPED     = THREADS * LREGS,
  localparam int unsigned FREE_DEPTH = PREGS - MAPPED,
  localparam int unsigned CNT_W      = $clog2(FREE_DEPTH + 1),
  localparam int unsigned SCW        = $clog2(SLOTS + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [TID_W-1:0]              ren_tid_i,
  input  logic [SLOTS-1:0]              ren_valid_i,
  input  logic [SLOTS-1:0]              ren_dst_valid_i,
  input  logic [SLOTS-1:0][LOG_W-1:0]   ren_dst_i,
  input  logic [SLOTS-1:0][LOG_W-1:0]   ren_srca_i,
  input  logic [SLOTS-1:0][LOG_W-1:0]   ren_srcb_i,
  output logic                          ren_accept_o,
  output logic [SLOTS-1:0]              ren_alloc_o,
  output logic [SLOTS-1:0][PHYS_W-1:0]  ren_pdst_o,
  output logic [SLOTS-1:0][PHYS_W-1:0]  ren_pold_o,
  output logic [SLOTS-1:0][PHYS_W-1:0]  ren_psrca_o,
  output logic [SLOTS-1:0][PHYS_W-1:0]  ren_psrcb_o,
  input  logic                          rel_valid_i,
  input  logic [PHYS_W-1:0]             rel_tag_i,
  input  logic                          restore_valid_i,
  input  logic [TID_W-1:0]              restore_tid_i
);

  logic [SLOTS-1:0][PHYS_W-1:0] tbl_a, tbl_b, tbl_d;
  logic [SLOTS-1:0][PHYS_W-1:0] peek;
  logic [CNT_W-1:0]             fl_count;
  logic [SCW-1:0]               pop_cnt;
  logic                         blocked;

  assign blocked = restore_valid_i && (restore_tid_i == ren_tid_i);

  rn_map_table #(
    .THREADS(THREADS), .LREGS(LREGS), .SLOTS(SLOTS),
    .TID_W(TID_W), .LOG_W(LOG_W), .PHYS_W(PHYS_W)
  ) u_map (
    .clk        (clk),
    .rst_n      (rst_n),
    .tid        (ren_tid_i),
    .rd_a       (ren_srca_i),
    .rd_b       (ren_srcb_i),
    .rd_d       (ren_dst_i),
    .tbl_a      (tbl_a),
    .tbl_b      (tbl_b),
    .tbl_d      (tbl_d),
    .wr_en      (ren_alloc_o),
    .wr_tag     (ren_pdst_o),
    .restore_en (restore_valid_i),
    .restore_tid(restore_tid_i)
  );

  rn_free_list #(
    .SLOTS(SLOTS), .FIRST(MAPPED), .DEPTH(FREE_DEPTH),
    .PHYS_W(PHYS_W), .CNT_W(CNT_W), .SCW(SCW)
  ) u_free (
    .clk     (clk),
    .rst_n   (rst_n),
    .pop_cnt (pop_cnt),
    .push_en (rel_valid_i),
    .push_tag(rel_tag_i),
    .peek    (peek),
    .count   (fl_count)
  );

  rn_group #(
    .SLOTS(SLOTS), .LOG_W(LOG_W), .PHYS_W(PHYS_W), .CNT_W(CNT_W), .SCW(SCW)
  ) u_grp (
    .valid    (ren_valid_i),
    .dst_valid(ren_dst_valid_i),
    .dst      (ren_dst_i),
    .srca     (ren_srca_i),
    .srcb     (ren_srcb_i),
    .tbl_a    (tbl_a),
    .tbl_b    (tbl_b),
    .tbl_d    (tbl_d),
    .peek     (peek),
    .free_cnt (fl_count),
    .blocked  (blocked),
    .accept   (ren_accept_o),
    .alloc    (ren_alloc_o),
    .pop_cnt  (pop_cnt),
    .pdst     (ren_pdst_o),
    .pold     (ren_pold_o),
    .psa      (ren_psrca_o),
    .psb      (ren_psrcb_o)
  );

endmodule

// File: rtl/rn_checker.sv
module rn_checker #(
  parameter int unsigned SLOTS  = 3,
  parameter int unsigned TID_W  = 1,
  parameter int unsigned LOG_W  = 5,
  parameter int unsigned PHYS_W = 7,
  parameter int unsigned CNT_W  = 6,
  parameter int unsigned DEPTH  = 32
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [TID_W-1:0]              ren_tid_i,
  input logic [SLOTS-1:0]              ren_valid_i,
  input logic [SLOTS-1:0]              ren_dst_valid_i,
  input logic [SLOTS-1:0][LOG_W-1:0]   ren_dst_i,
  input logic [SLOTS-1:0][LOG_W-1:0]   ren_srca_i,
  input logic [SLOTS-1:0][LOG_W-1:0]   ren_srcb_i,
  input logic                          ren_accept_o,
  input logic [SLOTS-1:0]              ren_alloc_o,
  input logic [SLOTS-1:0][PHYS_W-1:0]  ren_pdst_o,
  input logic [SLOTS-1:0][PHYS_W-1:0]  ren_pold_o,
  input logic [SLOTS-1:0][PHYS_W-1:0]  ren_psrca_o,
  input logic [SLOTS-1:0][PHYS_W-1:0]  ren_psrcb_o,
  input logic                          restore_valid_i,
  input logic [TID_W-1:0]              restore_tid_i,
  input logic [CNT_W-1:0]              fl_count
);

  p_idle_no_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(|ren_valid_i) |-> !ren_accept_o);

  p_restore_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (restore_valid_i && restore_tid_i == ren_tid_i) |-> !ren_accept_o);

  p_alloc_fits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ren_accept_o |-> ($countones(ren_alloc_o) <= int'(fl_count)));

  p_stall_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ren_accept_o |-> (ren_alloc_o == '0));

  p_count_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fl_count) <= int'(DEPTH));

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    p_no_alloc_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!ren_valid_i[s] || !ren_dst_valid_i[s] || ren_dst_i[s] == '0) |-> !ren_alloc_o[s]);
  end

  if (SLOTS >= 2) begin : g_pair
    p_fwd_srca_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ren_alloc_o[0] && ren_srca_i[1] == ren_dst_i[0]) |-> (ren_psrca_o[1] == ren_pdst_o[0]));
    p_fwd_srcb_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ren_alloc_o[0] && ren_srcb_i[1] == ren_dst_i[0]) |-> (ren_psrcb_o[1] == ren_pdst_o[0]));
    p_dst_chain_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ren_alloc_o[0] && ren_alloc_o[1] && ren_dst_i[0] == ren_dst_i[1]) |->
      (ren_pold_o[1] == ren_pdst_o[0]));
    p_distinct_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ren_alloc_o[0] && ren_alloc_o[1]) |-> (ren_pdst_o[0] != ren_pdst_o[1]));
  end

endmodule

bind mt_rename rn_checker #(
  .SLOTS(SLOTS), .TID_W(TID_W), .LOG_W(LOG_W),
  .PHYS_W(PHYS_W), .CNT_W(CNT_W), .DEPTH(FREE_DEPTH)
) u_rn_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .ren_tid_i      (ren_tid_i),
  .ren_valid_i    (ren_valid_i),
  .ren_dst_valid_i(ren_dst_valid_i),
  .ren_dst_i      (ren_dst_i),
  .ren_srca_i     (ren_srca_i),
  .ren_srcb_i     (ren_srcb_i),
  .ren_accept_o   (ren_accept_o),
  .ren_alloc_o    (ren_alloc_o),
  .ren_pdst_o     (ren_pdst_o),
  .ren_pold_o     (ren_pold_o),
  .ren_psrca_o    (ren_psrca_o),
  .ren_psrcb_o    (ren_psrcb_o),
  .restore_valid_i(restore_valid_i),
  .restore_tid_i  (restore_tid_i),
  .fl_count       (fl_count)
);

// File: tb/test_mt_rename.sv
module test_mt_rename;

  localparam int CLK_PERIOD = 10;
  localparam int SLOTS  = 3;
  localparam int LOG_W  = 5;
  localparam int PHYS_W = 7;
  localparam int TID_W  = 1;

  logic clk;
  logic rst_n;
  logic [TID_W-1:0]             ren_tid_i;
  logic [SLOTS-1:0]             ren_valid_i;
  logic [SLOTS-1:0]             ren_dst_valid_i;
  logic [SLOTS-1:0][LOG_W-1:0]  ren_dst_i;
  logic [SLOTS-1:0][LOG_W-1:0]  ren_srca_i;
  logic [SLOTS-1:0][LOG_W-1:0]  ren_srcb_i;
  logic                         ren_accept_o;
  logic [SLOTS-1:0]             ren_alloc_o;
  logic [SLOTS-1:0][PHYS_W-1:0] ren_pdst_o;
  logic [SLOTS-1:0][PHYS_W-1:0] ren_pold_o;
  logic [SLOTS-1:0][PHYS_W-1:0] ren_psrca_o;
  logic [SLOTS-1:0][PHYS_W-1:0] ren_psrcb_o;
  logic                         rel_valid_i;
  logic [PHYS_W-1:0]            rel_tag_i;
  logic                         restore_valid_i;
  logic [TID_W-1:0]             restore_tid_i;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  mt_rename i_mt_rename (
    .clk(clk), .rst_n(rst_n),
    .ren_tid_i(ren_tid_i), .ren_valid_i(ren_valid_i), .ren_dst_valid_i(ren_dst_valid_i),
    .ren_dst_i(ren_dst_i), .ren_srca_i(ren_srca_i), .ren_srcb_i(ren_srcb_i),
    .ren_accept_o(ren_accept_o), .ren_alloc_o(ren_alloc_o), .ren_pdst_o(ren_pdst_o),
    .ren_pold_o(ren_pold_o), .ren_psrca_o(ren_psrca_o), .ren_psrcb_o(ren_psrcb_o),
    .rel_valid_i(rel_valid_i), .rel_tag_i(rel_tag_i),
    .restore_valid_i(restore_valid_i), .restore_tid_i(restore_tid_i)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    int req;
    int tid; int v; int dv;
    int d0; int d1; int d2;
    int a0; int a1; int a2;
    int b0; int b1; int b2;
    int acc; int am;
    int p0; int p1; int p2;
    int o0; int o1; int o2;
    int x0; int x1; int x2;
    int y0; int y1; int y2;
  } vec_t;

  localparam int NVEC = 6;
  // -1 marks a value not checked
  localparam vec_t VECS [NVEC] = '{
    // R1 thread 0 reads at reset
    '{1, 0,7,0, 0,0,0, 1,2,3, 31,0,5, 1,0, -1,-1,-1, -1,-1,-1, 1,2,3, 31,0,5},
    // R2 thread 1 reads the same logical numbers
    '{2, 1,7,0, 0,0,0, 1,2,3, 31,0,5, 1,0, -1,-1,-1, -1,-1,-1, 33,34,35, 63,32,37},
    // R5 R6 R3 in-group forwarding and double write
    '{5, 0,7,7, 5,6,5, 5,5,6, 1,6,5, 1,7, 64,65,66, 5,6,64, 5,64,65, 1,6,64},
    // R7 thread 1: dst-valid 0 on slot 1, dst 0 on slot 2
    '{7, 1,7,5, 5,9,0, 5,5,9, 6,0,0, 1,1, 67,-1,-1, 37,-1,-1, 37,67,41, 38,32,32},
    // R4 thread 0 sees its updated table, invalid slot 2 allocates nothing
    '{4, 0,3,4, 0,0,7, 5,6,7, 0,0,0, 1,0, -1,-1,-1, -1,-1,-1, 66,65,-1, 0,0,-1},
    // R11 empty group
    '{11, 0,0,0, 0,0,0, 0,0,0, 0,0,0, 0,0, -1,-1,-1, -1,-1,-1, -1,-1,-1, -1,-1,-1}
  };

  task automatic chk(string req, string what, int act, int exp);
    if (exp < 0) return;
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive(int tid, int v, int dv, int d0, int d1, int d2,
                       int a0, int a1, int a2, int b0, int b1, int b2);
    ren_tid_i       = TID_W'(tid);
    ren_valid_i     = SLOTS'(v);
    ren_dst_valid_i = SLOTS'(dv);
    ren_dst_i[0] = LOG_W'(d0); ren_dst_i[1] = LOG_W'(d1); ren_dst_i[2] = LOG_W'(d2);
    ren_srca_i[0] = LOG_W'(a0); ren_srca_i[1] = LOG_W'(a1); ren_srca_i[2] = LOG_W'(a2);
    ren_srcb_i[0] = LOG_W'(b0); ren_srcb_i[1] = LOG_W'(b1); ren_srcb_i[2] = LOG_W'(b2);
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic advance();
    @(posedge clk);
    #1;
    rel_valid_i     = 1'b0;
    restore_valid_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    rel_valid_i = 1'b0; rel_tag_i = '0;
    restore_valid_i = 1'b0; restore_tid_i = '0;
    drive(0, 0,0, 0,0,0, 0,0,0, 0,0,0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R11 reset state with nothing presented
    settle();
    chk("R11", "accept idle", int'(ren_accept_o), 0);
    chk("R7", "alloc idle", int'(ren_alloc_o), 0);
    advance();

    // table walk
    for (int k = 0; k < NVEC; k++) begin
      vec_t t;
      string tag;
      t = VECS[k];
      tag = $sformatf("R%0d", t.req);
      drive(t.tid, t.v, t.dv, t.d0, t.d1, t.d2, t.a0, t.a1, t.a2, t.b0, t.b1, t.b2);
      settle();
      chk(tag, "accept", int'(ren_accept_o), t.acc);
      chk(tag, "alloc", int'(ren_alloc_o), t.am);
      chk(tag, "pdst0", int'(ren_pdst_o[0]), t.p0);
      chk(tag, "pdst1", int'(ren_pdst_o[1]), t.p1);
      chk(tag, "pdst2", int'(ren_pdst_o[2]), t.p2);
      chk(tag, "pold0", int'(ren_pold_o[0]), t.o0);
      chk(tag, "pold1", int'(ren_pold_o[1]), t.o1);
      chk(tag, "pold2", int'(ren_pold_o[2]), t.o2);
      chk(tag, "psrca0", int'(ren_psrca_o[0]), t.x0);
      chk(tag, "psrca1", int'(ren_psrca_o[1]), t.x1);
      chk(tag, "psrca2", int'(ren_psrca_o[2]), t.x2);
      chk(tag, "psrcb0", int'(ren_psrcb_o[0]), t.y0);
      chk(tag, "psrcb1", int'(ren_psrcb_o[1]), t.y1);
      chk(tag, "psrcb2", int'(ren_psrcb_o[2]), t.y2);
      advance();
    end

    // R3 drain: 28 entries left, handed out in order starting at 68
    for (int g = 0; g < 9; g++) begin
      drive(0, 7,7, 1,2,3, 0,0,0, 0,0,0);
      settle();
      chk("R3", "drain accept", int'(ren_accept_o), 1);
      for (int s = 0; s < 3; s++) chk("R3", "drain pdst", int'(ren_pdst_o[s]), 68 + 3*g + s);
      advance();
    end
    // R8 one entry left, group needs three
    drive(0, 7,7, 1,2,3, 0,0,0, 0,0,0);
    settle();
    chk("R8", "short accept", int'(ren_accept_o), 0);
    chk("R8", "short alloc", int'(ren_alloc_o), 0);
    advance();
    // R8 exact fit takes the last entry; R4 old mapping
    drive(0, 1,1, 4,0,0, 0,0,0, 0,0,0);
    settle();
    chk("R8", "fit accept", int'(ren_accept_o), 1);
    chk("R8", "fit pdst", int'(ren_pdst_o[0]), 95);
    chk("R4", "fit pold", int'(ren_pold_o[0]), 4);
    advance();
    // R8 stalled group left the table alone
    drive(0, 1,0, 0,0,0, 1,0,0, 2,0,0);
    settle();
    chk("R8", "no-dest accept on empty list", int'(ren_accept_o), 1);
    chk("R8", "table after stall a", int'(ren_psrca_o[0]), 92);
    chk("R8", "table after stall b", int'(ren_psrcb_o[0]), 93);
    advance();
    drive(0, 1,1, 7,0,0, 0,0,0, 0,0,0);
    settle();
    chk("R8", "empty accept", int'(ren_accept_o), 0);
    advance();

    // R9 release port
    rel_valid_i = 1'b1; rel_tag_i = PHYS_W'(5);
    drive(0, 1,1, 7,0,0, 0,0,0, 0,0,0);
    settle();
    chk("R9", "same-cycle release unusable", int'(ren_accept_o), 0);
    advance();
    rel_valid_i = 1'b1; rel_tag_i = PHYS_W'(6);
    drive(0, 1,1, 7,0,0, 0,0,0, 0,0,0);
    settle();
    chk("R9", "first release accept", int'(ren_accept_o), 1);
    chk("R9", "first release tag", int'(ren_pdst_o[0]), 5);
    advance();
    drive(0, 1,1, 7,0,0, 0,0,0, 0,0,0);
    settle();
    chk("R9", "second release tag", int'(ren_pdst_o[0]), 6);
    chk("R4", "pold from previous group", int'(ren_pold_o[0]), 5);
    advance();
    drive(0, 1,1, 7,0,0, 0,0,0, 0,0,0);
    settle();
    chk("R9", "list empty again", int'(ren_accept_o), 0);
    advance();

    // R10 restore
    restore_valid_i = 1'b1; restore_tid_i = 1'b0;
    drive(0, 1,0, 0,0,0, 1,0,0, 0,0,0);
    settle();
    chk("R10", "same-thread group rejected", int'(ren_accept_o), 0);
    advance();
    drive(0, 3,0, 0,0,0, 1,7,0, 5,0,0);
    settle();
    chk("R10", "restored r1", int'(ren_psrca_o[0]), 1);
    chk("R10", "restored r7", int'(ren_psrca_o[1]), 7);
    chk("R10", "restored r5", int'(ren_psrcb_o[0]), 5);
    advance();
    drive(1, 1,0, 0,0,0, 5,0,0, 0,0,0);
    settle();
    chk("R2", "thread 1 kept its map", int'(ren_psrca_o[0]), 67);
    advance();
    restore_valid_i = 1'b1; restore_tid_i = 1'b1;
    drive(0, 1,0, 0,0,0, 1,0,0, 0,0,0);
    settle();
    chk("R10", "other thread renames", int'(ren_accept_o), 1);
    advance();
    drive(1, 1,0, 0,0,0, 5,0,0, 0,0,0);
    settle();
    chk("R10", "thread 1 restored", int'(ren_psrca_o[0]), 37);
    advance();
    drive(0, 1,1, 3,0,0, 0,0,0, 0,0,0);
    settle();
    chk("R10", "free list untouched", int'(ren_accept_o), 0);
    advance();

    // R1 R3 reset again
    rst_n = 1'b0;
    @(posedge clk);
    #1 rst_n = 1'b1;
    drive(1, 1,1, 5,0,0, 5,0,0, 0,0,0);
    settle();
    chk("R3", "alloc after reset", int'(ren_pdst_o[0]), 64);
    chk("R1", "pold after reset", int'(ren_pold_o[0]), 37);
    chk("R1", "src after reset", int'(ren_psrca_o[0]), 37);
    advance();

    finish_run();
  end

endmodule